// File: doc/BRIEF.md
# Line Brown-In Supervisor with Soft Start

This block decides when a power-factor correction stage may run. It watches a measured RMS line-voltage value. The stage is released only after the line has stayed in the healthy range for a qualification interval. A sag below a lower threshold switches it off at once. Between the two thresholds the current decision is kept, which gives hysteresis against a line that hovers near one level.

While running, the block produces two soft-start quantities, and both advance only on a slow tick. The first is an output-voltage reference that walks toward a requested setpoint in programmable steps and never passes it. The second is a clamp limit for the current-loop compensator output, which climbs from zero to a fixed ceiling. Every time the stage is disabled, both quantities return to zero and the qualification interval starts over.

A duty-gate output allows switching only while the stage is enabled and the instantaneous scaled line voltage is at or above a shoulder level. Near the line zero crossings it forces zero duty. The RMS computation and the compensators themselves sit outside this block.

Top module: `brownin_supervisor`

## Requirements
- R1: With `run_en` low, `run_en` rises at the clock edge of the QUAL_TICKS-th consecutive `tick` with `vrms >= V_ON`. Any clock cycle with `vrms < V_ON` before that restarts the count.
- R2: Whenever `vrms < V_OFF` at a clock edge, `run_en` is low after that edge, whether or not `tick` is high.
- R3: After a drop-out, enabling again needs a complete fresh qualification of QUAL_TICKS good ticks.
- R4: While `run_en` is high and `V_OFF <= vrms < V_ON`, `run_en` stays high.
- R5: On each tick at which the block is or becomes enabled, `vref_slewed` moves toward `vtarget` by `slew_step`. This includes the tick that grants enable. It lands exactly on `vtarget` and never passes it, in either direction.
- R6: On each such tick, `clamp_lim` rises by `clamp_step` and saturates at CLAMP_MAX.
- R7: After reset, and at every edge where the block ends up disabled, `run_en`, `vref_slewed`, `clamp_lim` and `duty_gate` are all zero.
- R8: `duty_gate` is a registered value. After an edge it is 1 only if the block was enabled after that edge and `vinst >= V_SHOULDER` held before it.
- R9: On clock edges without `tick`, `vref_slewed` and `clamp_lim` do not change, unless the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base strobe, one clock wide |
| vrms | input | W | Measured RMS line voltage |
| vinst | input | W | Instantaneous scaled line voltage |
| vtarget | input | W | Requested output-voltage setpoint |
| slew_step | input | W | Reference increment per tick |
| clamp_step | input | W | Clamp-limit increment per tick |
| run_en | output | 1 | Controller enable |
| vref_slewed | output | W | Slew-limited output-voltage reference |
| clamp_lim | output | W | Current-loop output clamp limit |
| duty_gate | output | 1 | 1 allows switching, 0 forces zero duty |

## Verification
The RMS input is swept across both thresholds, one value per cycle and one value per tick. This separates the immediate drop-out from the held hysteresis band and from the qualification restart. Qualification is interrupted once by a value in the band and once by a value below the lower threshold, to confirm that either one discards the partial count. The setpoint is raised with a step that does not divide it evenly, and later lowered, so that landing exactly on the target is exercised in both directions. The ticks are spaced irregularly, so any movement between ticks shows up. The instantaneous voltage is swept through the shoulder level while enabled and again while disabled, to tell the threshold comparison apart from the enable qualification.

// File: rtl/brownin_pkg.sv
package brownin_pkg;
  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_GOOD = 2'd2
  } line_band_e;
endpackage

// File: rtl/brownin_qualifier.sv
module brownin_qualifier #(
  parameter int W          = 12,
  parameter int QUAL_TICKS = 1500,
  parameter int V_ON       = 115,
  parameter int V_OFF      = 90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] vrms,
  output logic         en_q,
  output logic         en_nxt
);
  import brownin_pkg::*;

  localparam int              CW      = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0]   LAST    = CW'(QUAL_TICKS - 1);
  localparam logic [W-1:0]    ON_LVL  = W'(V_ON);
  localparam logic [W-1:0]    OFF_LVL = W'(V_OFF);

  line_band_e    band;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_d;

  always_comb begin
    if (vrms < OFF_LVL)     band = BAND_LOW;
    else if (vrms < ON_LVL) band = BAND_MID;
    else                    band = BAND_GOOD;
  end

  always_comb begin
    en_d  = en_q;
    cnt_d = cnt_q;
    unique case (band)
      BAND_LOW: begin
        en_d  = 1'b0;
        cnt_d = '0;
      end
      BAND_MID: begin
        if (!en_q) cnt_d = '0;
      end
      BAND_GOOD: begin
        if (!en_q && tick) begin
          if (cnt_q == LAST) begin
            en_d  = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        en_d  = 1'b0;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  assign en_nxt = en_d;
endmodule

// File: rtl/brownin_ramp.sv
module brownin_ramp #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] goal,
  input  logic [W-1:0] step,
  output logic [W-1:0] level
);
  logic [W-1:0] lvl_q, lvl_d;
  logic [W:0]   up_sum;
  logic [W-1:0] down_gap;

  always_comb begin
    up_sum   = {1'b0, lvl_q} + {1'b0, step};
    down_gap = lvl_q - goal;
    lvl_d    = lvl_q;
    if (!run) begin
      lvl_d = '0;
    end else if (tick) begin
      if (lvl_q < goal) begin
        lvl_d = (up_sum >= {1'b0, goal}) ? goal : up_sum[W-1:0];
      end else if (lvl_q > goal) begin
        lvl_d = (down_gap <= step) ? goal : (lvl_q - step);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/brownin_shoulder.sv
module brownin_shoulder #(
  parameter int W          = 12,
  parameter int V_SHOULDER = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] vinst,
  output logic         gate
);
  localparam logic [W-1:0] SH_LVL = W'(V_SHOULDER);

  logic gate_q, gate_d;

  always_comb gate_d = run && (vinst >= SH_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate = gate_q;
endmodule

// File: rtl/brownin_supervisor.sv
module brownin_supervisor #(
  parameter int W          = 12,
  parameter int QUAL_TICKS = 1500,
  parameter int V_ON       = 115,
  parameter int V_OFF      = 90,
  parameter int V_SHOULDER = 20,
  parameter int CLAMP_MAX  = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] vrms,
  input  logic [W-1:0] vinst,
  input  logic [W-1:0] vtarget,
  input  logic [W-1:0] slew_step,
  input  logic [W-1:0] clamp_step,
  output logic         run_en,
  output logic [W-1:0] vref_slewed,
  output logic [W-1:0] clamp_lim,
  output logic         duty_gate
);
  localparam logic [W-1:0] CLAMP_TOP = W'(CLAMP_MAX);

  logic en_q, en_nxt;

  brownin_qualifier #(
    .W(W), .QUAL_TICKS(QUAL_TICKS), .V_ON(V_ON), .V_OFF(V_OFF)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vrms(vrms),
    .en_q(en_q), .en_nxt(en_nxt)
  );

  brownin_ramp #(.W(W)) u_ref_ramp (
    .clk(clk), .rst_n(rst_n), .run(en_nxt), .tick(tick),
    .goal(vtarget), .step(slew_step), .level(vref_slewed)
  );

  brownin_ramp #(.W(W)) u_clamp_ramp (
    .clk(clk), .rst_n(rst_n), .run(en_nxt), .tick(tick),
    .goal(CLAMP_TOP), .step(clamp_step), .level(clamp_lim)
  );

  brownin_shoulder #(.W(W), .V_SHOULDER(V_SHOULDER)) u_gate (
    .clk(clk), .rst_n(rst_n), .run(en_nxt), .vinst(vinst), .gate(duty_gate)
  );

  assign run_en = en_q;
endmodule

// File: rtl/brownin_supervisor_chk.sv
module brownin_supervisor_chk #(
  parameter int W          = 12,
  parameter int V_ON       = 115,
  parameter int V_OFF      = 90,
  parameter int V_SHOULDER = 20,
  parameter int CLAMP_MAX  = 1000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] vrms,
  input logic [W-1:0] vinst,
  input logic [W-1:0] vtarget,
  input logic         run_en,
  input logic [W-1:0] vref_slewed,
  input logic [W-1:0] clamp_lim,
  input logic         duty_gate
);
  localparam logic [W-1:0] ON_LVL  = W'(V_ON);
  localparam logic [W-1:0] OFF_LVL = W'(V_OFF);
  localparam logic [W-1:0] SH_LVL  = W'(V_SHOULDER);
  localparam logic [W-1:0] TOP     = W'(CLAMP_MAX);

  assert_rise_needs_good_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> ($past(vrms) >= ON_LVL && $past(tick)));

  assert_low_line_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vrms < OFF_LVL) |=> !run_en);

  assert_band_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && vrms >= OFF_LVL) |=> run_en);

  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(vtarget) && $past(vref_slewed) <= $past(vtarget)) |-> (vref_slewed <= vtarget));

  assert_clamp_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_lim <= TOP);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (vref_slewed == '0 && clamp_lim == '0 && !duty_gate));

  assert_shoulder_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vinst < SH_LVL) |=> !duty_gate);

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && run_en && vrms >= OFF_LVL) |=> ($stable(vref_slewed) && $stable(clamp_lim)));
endmodule

bind brownin_supervisor brownin_supervisor_chk #(
  .W(W), .V_ON(V_ON), .V_OFF(V_OFF), .V_SHOULDER(V_SHOULDER), .CLAMP_MAX(CLAMP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vrms(vrms), .vinst(vinst),
  .vtarget(vtarget), .run_en(run_en), .vref_slewed(vref_slewed),
  .clamp_lim(clamp_lim), .duty_gate(duty_gate)
);

// File: tb/brownin_supervisor_tb.sv
module brownin_supervisor_tb;
  localparam int W    = 12;
  localparam int QUAL = 5;
  localparam int VON  = 115;
  localparam int VOFF = 90;
  localparam int VSH  = 20;
  localparam int CMAX = 100;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick;
  logic [W-1:0] vrms, vinst, vtarget, slew_step, clamp_step;
  logic         run_en, duty_gate;
  logic [W-1:0] vref_slewed, clamp_lim;

  int n_checks = 0;
  int n_errors = 0;
  string req = "R7";

  int m_en, m_cnt, m_ref, m_clamp, m_gate;

  always #2.5 clk = ~clk;

  brownin_supervisor #(
    .W(W), .QUAL_TICKS(QUAL), .V_ON(VON), .V_OFF(VOFF),
    .V_SHOULDER(VSH), .CLAMP_MAX(CMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vrms(vrms), .vinst(vinst),
    .vtarget(vtarget), .slew_step(slew_step), .clamp_step(clamp_step),
    .run_en(run_en), .vref_slewed(vref_slewed), .clamp_lim(clamp_lim),
    .duty_gate(duty_gate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s (%s): actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  function automatic int toward(input int lvl, input int goal, input int st);
    if (lvl < goal) return (lvl + st >= goal) ? goal : lvl + st;
    if (lvl > goal) return (lvl - goal <= st) ? goal : lvl - st;
    return lvl;
  endfunction

  task automatic model_step();
    int vr = int'(vrms);
    if (vr < VOFF) begin
      m_en = 0; m_cnt = 0;
    end else if (m_en == 0) begin
      if (vr < VON) m_cnt = 0;
      else if (tick) begin
        if (m_cnt == QUAL - 1) begin m_en = 1; m_cnt = 0; end
        else m_cnt++;
      end
    end
    if (m_en == 0) begin
      m_ref = 0; m_clamp = 0;
    end else if (tick) begin
      m_ref   = toward(m_ref, int'(vtarget), int'(slew_step));
      m_clamp = toward(m_clamp, CMAX, int'(clamp_step));
    end
    m_gate = (m_en != 0 && int'(vinst) >= VSH) ? 1 : 0;
  endtask

  task automatic cyc(input logic tk);
    tick = tk;
    @(posedge clk);
    model_step();
    #1;
    chk("run_en", int'(run_en), m_en);
    chk("vref_slewed", int'(vref_slewed), m_ref);
    chk("clamp_lim", int'(clamp_lim), m_clamp);
    chk("duty_gate", int'(duty_gate), m_gate);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      for (int g = 0; g < gap; g++) cyc(1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; vrms = '0; vinst = 12'd50;
    vtarget = 12'd390; slew_step = 12'd50; clamp_step = 12'd30;
    m_en = 0; m_cnt = 0; m_ref = 0; m_clamp = 0; m_gate = 0;
    repeat (3) @(negedge clk);
    req = "R7";
    chk("reset run_en", int'(run_en), 0);
    chk("reset vref", int'(vref_slewed), 0);
    chk("reset clamp", int'(clamp_lim), 0);
    chk("reset gate", int'(duty_gate), 0);
    rst_n = 1'b1;
    cyc(1'b0);

    // R1: qualification, interrupted once by a band value and once by low line
    req = "R1";
    vrms = 12'd120;
    ticks(3, 2);
    vrms = 12'd100; cyc(1'b0);
    vrms = 12'd120;
    ticks(4, 1);
    chk("still off after 4 ticks", int'(run_en), 0);
    vrms = 12'd60; cyc(1'b0);
    vrms = 12'd115;
    ticks(QUAL - 1, 2);
    chk("off before last tick", int'(run_en), 0);
    cyc(1'b1);
    chk("on at fifth tick", int'(run_en), 1);

    // R5 and R6: ramps with an uneven step, irregular tick spacing (R9)
    req = "R5";
    ticks(3, 3);
    req = "R9";
    ticks(2, 7);
    req = "R5";
    ticks(4, 0);
    chk("ref landed on target", int'(vref_slewed), 390);
    req = "R6";
    chk("clamp at ceiling", int'(clamp_lim), CMAX);

    // R5: lowering the target
    req = "R5";
    vtarget = 12'd200; slew_step = 12'd45;
    ticks(6, 1);
    chk("ref landed on lower target", int'(vref_slewed), 200);

    // R4: hysteresis band held
    req = "R4";
    for (int v = VON - 1; v >= VOFF; v--) begin
      vrms = W'(v);
      cyc(1'b1);
    end
    chk("held in band", int'(run_en), 1);

    // R8: shoulder sweep while enabled
    req = "R8";
    for (int v = 0; v <= 40; v++) begin
      vinst = W'(v);
      cyc(1'b0);
    end

    // R2: one-cycle sag, no tick
    req = "R2";
    vrms = 12'd89; cyc(1'b0);
    chk("dropped at once", int'(run_en), 0);
    req = "R7";
    chk("ref zero after drop", int'(vref_slewed), 0);

    // R8: sweep while disabled
    req = "R8";
    for (int v = 0; v <= 40; v += 4) begin
      vinst = W'(v);
      cyc(1'b0);
    end

    // R3: full requalification after drop-out
    req = "R3";
    vrms = 12'd120; vtarget = 12'd390; slew_step = 12'd50;
    ticks(QUAL - 1, 0);
    chk("off after partial requal", int'(run_en), 0);
    ticks(1, 0);
    chk("on after full requal", int'(run_en), 1);

    // Threshold sweep of the RMS input, one value per tick
    req = "R2";
    for (int v = 80; v <= 125; v++) begin
      vrms = W'(v);
      cyc(1'b1);
    end
    for (int v = 125; v >= 80; v -= 3) begin
      vrms = W'(v);
      cyc(v % 2 == 0);
    end

    req = "R1";
    vrms = 12'd130;
    ticks(QUAL + 2, 1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule